// File: doc/BRIEF.md
# Pulse Accumulator with Write-Once Prescaler Select

This block counts pulses arriving on an external input. The input is resynchronised to the block clock. Each edge of the chosen polarity adds one to an 8-bit accumulator and sets a sticky edge flag. When the accumulator wraps from all ones to zero, it sets a sticky overflow flag. Two interrupt outputs each combine one of these flags with its enable bit.

Software reaches the block through a small synchronous register port. A write takes effect at the clock edge where `wr_en` is sampled high. Read data appears on `rdata` one cycle after `rd_en` is sampled. Reset leaves the accumulator value untouched, so a count survives a soft restart.

The interrupt-mask register also carries a two-bit timer prescaler select, which leaves the block as an output. In normal mode (`special_mode` low) this field accepts a single write, and only during the first 64 clock edges after reset. Once that write is taken, or the window has passed, the field is frozen until the next reset. In special mode the field can be rewritten without limit.

Register map (address on `addr`):
- 0: accumulator value, bits 7:0, read/write.
- 1: mask register.
  - Bit 7: timer-overflow enable. Bit 6: real-time enable. Both are only exported.
  - Bit 5: accumulator-overflow interrupt enable. Bit 4: accumulator-edge interrupt enable.
  - Bits 3:2 read zero.
  - Bits 1:0: prescaler select.
- 2: control and flags.
  - Bit 7: edge flag. Bit 6: overflow flag. Writing 1 to either bit clears it.
  - Bit 0: edge polarity, 1 = rising, 0 = falling.
  - Other bits read zero.
- 3: unused, reads zero.

Top module: `pa_accum`

## Requirements
- R1: A write to address 0 loads the accumulator, and a read of address 0 returns it. Asserting reset does not change the accumulator value.
- R2: Each edge on `pulse_in` of the polarity chosen by control bit 0 (1 = rising, the reset value; 0 = falling) adds one to the accumulator. An edge of the other polarity leaves it unchanged. The accumulator changes within five clock cycles of the input change.
- R3: An increment that takes the accumulator from 0xFF to 0x00 sets the overflow flag (control bit 6). `irq_acc_ovf` is high exactly when that flag and mask bit 5 are both 1.
- R4: Each counted edge sets the edge flag (control bit 7). `irq_acc_edge` is high exactly when that flag and mask bit 4 are both 1.
- R5: Writing 1 to control bit 7 or bit 6 clears that flag, and writing 0 leaves it. If a new edge or overflow occurs in the same cycle as a clear, the flag stays set.
- R6: Mask bits 7:4 can be written at any time and reset to 0. Mask bit 7 drives `tmr_ovf_en` and mask bit 6 drives `rt_en`. Mask bits 3:2 always read 0.
- R7: In normal mode, the first write to address 1 made at clock edges 0 to 63 after reset release loads the prescaler select (mask bits 1:0, reset value 00, driven on `prescale`). Every later write leaves the field unchanged.
- R8: In normal mode, a write to address 1 at clock edge 64 or later after reset release leaves the prescaler select unchanged.
- R9: In special mode, every write to address 1 loads the prescaler select.
- R10: If a write to address 0 and a counted edge fall in the same cycle, the written value is kept and the increment is dropped. The edge flag is still set.
- R11: `rdata` shows the addressed register one cycle after `rd_en`. Address 3 and all unused bits read 0. `rdata` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | 1 = prescaler field writable at any time |
| pulse_in | input | 1 | Asynchronous pulse input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_acc_ovf | output | 1 | Accumulator overflow interrupt |
| irq_acc_edge | output | 1 | Accumulator input-edge interrupt |
| tmr_ovf_en | output | 1 | Exported timer-overflow enable |
| rt_en | output | 1 | Exported real-time enable |
| prescale | output | 2 | Exported prescaler select |

## Verification
Two pairs of events can fall in the same cycle. In the first, a software write to the accumulator lands on the edge where a synchronised input edge would increment it. In the second, a write-1 clear of the edge flag lands on the edge where a new edge sets that flag. The bench raises `pulse_in` at a falling clock edge and counts the two synchroniser flops. It then places the register write on the third rising edge, where the increment would land. It judges the result by reading back the accumulator, which must hold the written value, and the flags, where the edge flag must remain set.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT = 2'd0,
    REG_MASK  = 2'd1,
    REG_CTRL  = 2'd2,
    REG_SPARE = 2'd3
  } reg_addr_e;

  // mask register bit positions
  localparam int MB_TMR_OVF = 7;
  localparam int MB_RT      = 6;
  localparam int MB_ACC_OVF = 5;
  localparam int MB_ACC_EDG = 4;
  localparam int PS_W       = 2;

  // control register bit positions
  localparam int CB_EDGE_F  = 7;
  localparam int CB_OVF_F   = 6;
  localparam int CB_RISE    = 0;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              cur;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign cur = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= cur;
  end

  always_comb begin
    if (rise_sel) hit = cur & ~prev;
    else          hit = ~cur & prev;
  end
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic         clr_ovf,
  output logic [W-1:0] count,
  output logic         ovf_flag
);
  logic wrap;

  assign wrap = inc & ~load & (count == {W{1'b1}});

  // value register is intentionally outside reset
  always_ff @(posedge clk) begin
    if (load)     count <= load_val;
    else if (inc) count <= count + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (clr_ovf) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/pa_regs.sv
module pa_regs
  import pa_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int WIN_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              special_mode,
  input  logic              wr_mask,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              edge_hit,
  output logic [3:0]        mask_en,
  output logic [PS_W-1:0]   prescale,
  output logic              rise_sel,
  output logic              edge_flag,
  output logic              ps_locked
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_CYC[WIN_W-1:0];

  logic [WIN_W-1:0] win_cnt;
  logic             win_open;
  logic             ps_taken;
  logic             ps_ok;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[3:2] ^ ^wdata[DATA_W-1:DATA_W-2];

  always_ff @(posedge clk) begin
    if (rst)                  win_cnt <= '0;
    else if (win_cnt != WIN_END) win_cnt <= win_cnt + 1'b1;
  end

  assign win_open  = (win_cnt != WIN_END);
  assign ps_ok     = special_mode | (win_open & ~ps_taken);
  assign ps_locked = ~ps_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_en  <= '0;
      prescale <= '0;
      ps_taken <= 1'b0;
    end else if (wr_mask) begin
      mask_en <= wdata[MB_TMR_OVF:MB_ACC_EDG];
      if (ps_ok) begin
        prescale <= wdata[PS_W-1:0];
        if (!special_mode) ps_taken <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rise_sel <= 1'b1;
    else if (wr_ctrl) rise_sel <= wdata[CB_RISE];
  end

  always_ff @(posedge clk) begin
    if (rst)                              edge_flag <= 1'b0;
    else if (edge_hit)                    edge_flag <= 1'b1;
    else if (wr_ctrl && wdata[CB_EDGE_F]) edge_flag <= 1'b0;
  end
endmodule

// File: rtl/pa_accum.sv
module pa_accum
  import pa_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int WIN_CYC     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              special_mode,
  input  logic              pulse_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_acc_ovf,
  output logic              irq_acc_edge,
  output logic              tmr_ovf_en,
  output logic              rt_en,
  output logic [PS_W-1:0]   prescale
);
  logic              wr_count, wr_mask, wr_ctrl;
  logic              edge_hit, rise_sel;
  logic [DATA_W-1:0] count;
  logic              ovf_flag, edge_flag, ps_locked;
  logic [3:0]        mask_en;
  logic [DATA_W-1:0] rd_mux;

  assign wr_count = wr_en && (addr == REG_COUNT);
  assign wr_mask  = wr_en && (addr == REG_MASK);
  assign wr_ctrl  = wr_en && (addr == REG_CTRL);

  pa_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pin      (pulse_in),
    .rise_sel (rise_sel),
    .hit      (edge_hit)
  );

  pa_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_count),
    .load_val (wdata),
    .inc      (edge_hit),
    .clr_ovf  (wr_ctrl & wdata[CB_OVF_F]),
    .count    (count),
    .ovf_flag (ovf_flag)
  );

  pa_regs #(.DATA_W(DATA_W), .WIN_CYC(WIN_CYC)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .special_mode (special_mode),
    .wr_mask      (wr_mask),
    .wr_ctrl      (wr_ctrl),
    .wdata        (wdata),
    .edge_hit     (edge_hit),
    .mask_en      (mask_en),
    .prescale     (prescale),
    .rise_sel     (rise_sel),
    .edge_flag    (edge_flag),
    .ps_locked    (ps_locked)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      REG_COUNT: rd_mux = count;
      REG_MASK: begin
        rd_mux[MB_TMR_OVF:MB_ACC_EDG] = mask_en;
        rd_mux[PS_W-1:0]              = prescale;
      end
      REG_CTRL: begin
        rd_mux[CB_EDGE_F] = edge_flag;
        rd_mux[CB_OVF_F]  = ovf_flag;
        rd_mux[CB_RISE]   = rise_sel;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign tmr_ovf_en   = mask_en[3];
  assign rt_en        = mask_en[2];
  assign irq_acc_ovf  = ovf_flag  & mask_en[1];
  assign irq_acc_edge = edge_flag & mask_en[0];
endmodule

// File: rtl/pa_accum_chk.sv
module pa_accum_chk
  import pa_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              special_mode,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] count,
  input logic              edge_hit,
  input logic              ovf_flag,
  input logic              ps_locked,
  input logic [PS_W-1:0]   prescale
);
  // R10: write wins over increment
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_COUNT) |=> (count == $past(wdata)));

  // R2: one step per counted edge
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && !(wr_en && addr == REG_COUNT)) |=> (count == $past(count) + 1'b1));

  // R3: wrap sets overflow flag
  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && !(wr_en && addr == REG_COUNT) && count == {DATA_W{1'b1}}) |=> ovf_flag);

  // R5: flag holds unless cleared
  a_r5_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(wr_en && addr == REG_CTRL && wdata[CB_OVF_F])) |=> ovf_flag);

  // R7 / R8: locked prescaler field holds in normal mode
  a_r7_ps_lock: assert property (@(posedge clk) disable iff (rst)
    (!special_mode && ps_locked) |=> $stable(prescale));

  // R6: reserved mask bits read zero
  a_r6_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_MASK) |=> (rdata[3:2] == 2'b00));
endmodule

bind pa_accum pa_accum_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .special_mode (special_mode),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .count        (count),
  .edge_hit     (edge_hit),
  .ovf_flag     (ovf_flag),
  .ps_locked    (ps_locked),
  .prescale     (prescale)
);

// File: tb/tb_pa_accum.sv
`timescale 1ns/1ps
module tb_pa_accum;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       special_mode = 1'b0;
  logic       pulse_in = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_acc_ovf, irq_acc_edge, tmr_ovf_en, rt_en;
  logic [1:0] prescale;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pa_accum dut (
    .clk(clk), .rst(rst), .special_mode(special_mode), .pulse_in(pulse_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_acc_ovf(irq_acc_ovf), .irq_acc_edge(irq_acc_edge),
    .tmr_ovf_en(tmr_ovf_en), .rt_en(rt_en), .prescale(prescale)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_pulse(input logic v);
    @(negedge clk) pulse_in = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    check("R11 rdata after reset", rdata, 8'h00);
    check("R7 prescale after reset", {6'd0, prescale}, 8'h00);
    rd(2'd1, v); check("R6 mask reset", v, 8'h00);
    rd(2'd2, v); check("R2 ctrl reset", v, 8'h01);
    check("R3 irq reset", {6'd0, irq_acc_ovf, irq_acc_edge}, 8'h00);
  endtask

  task automatic t_window_once();
    logic [7:0] v;
    wr(2'd1, 8'h02);
    check("R7 first write", {6'd0, prescale}, 8'h02);
    wr(2'd1, 8'h03);
    check("R7 second write ignored", {6'd0, prescale}, 8'h02);
    rd(2'd1, v); check("R7 readback", v, 8'h02);
  endtask

  task automatic t_keep_count();
    logic [7:0] v;
    wr(2'd0, 8'h5A);
    do_reset();
    rd(2'd0, v); check("R1 count kept over reset", v, 8'h5A);
    rd(2'd3, v); check("R11 spare reads zero", v, 8'h00);
  endtask

  task automatic t_window_edge(input int n, input logic [1:0] exp);
    do_reset();
    repeat (n) @(posedge clk);
    wr(2'd1, 8'h01);
    if (n < 64) check("R7 write at last open edge", {6'd0, prescale}, {6'd0, exp});
    else        check("R8 write after window", {6'd0, prescale}, {6'd0, exp});
  endtask

  task automatic t_rising();
    logic [7:0] v;
    wr(2'd0, 8'h10);
    wr(2'd2, 8'hC1);
    set_pulse(1'b1);
    rd(2'd0, v); check("R2 rising counted", v, 8'h11);
    rd(2'd2, v); check("R4 edge flag set", v, 8'h81);
    set_pulse(1'b0);
    rd(2'd0, v); check("R2 falling not counted", v, 8'h11);
  endtask

  task automatic t_falling();
    logic [7:0] v;
    wr(2'd2, 8'hC0);
    rd(2'd2, v); check("R5 flags cleared, falling selected", v, 8'h00);
    set_pulse(1'b1);
    rd(2'd0, v); check("R2 rising ignored in falling mode", v, 8'h11);
    set_pulse(1'b0);
    rd(2'd0, v); check("R2 falling counted", v, 8'h12);
    wr(2'd2, 8'hC1);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr(2'd1, 8'h20);
    wr(2'd0, 8'hFF);
    set_pulse(1'b1);
    rd(2'd0, v); check("R3 wrap to zero", v, 8'h00);
    rd(2'd2, v); check("R3 overflow flag", v, 8'hC1);
    check("R3 irq_acc_ovf high", {7'd0, irq_acc_ovf}, 8'h01);
    check("R4 irq_acc_edge masked", {7'd0, irq_acc_edge}, 8'h00);
    wr(2'd2, 8'h41);
    rd(2'd2, v); check("R5 clear overflow only", v, 8'h81);
    check("R3 irq_acc_ovf low after clear", {7'd0, irq_acc_ovf}, 8'h00);
    wr(2'd1, 8'h10);
    check("R4 irq_acc_edge enabled", {7'd0, irq_acc_edge}, 8'h01);
    wr(2'd2, 8'h81);
    check("R4 irq_acc_edge after clear", {7'd0, irq_acc_edge}, 8'h00);
    set_pulse(1'b0);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_collide_write();
    logic [7:0] v;
    wr(2'd2, 8'hC1);
    @(negedge clk) pulse_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h40;
    @(negedge clk) wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R10 write beats increment", v, 8'h40);
    rd(2'd2, v); check("R10 edge flag still set", v, 8'h81);
    set_pulse(1'b0);
  endtask

  task automatic t_collide_clear();
    logic [7:0] v;
    wr(2'd2, 8'hC1);
    @(negedge clk) pulse_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 8'h81;
    @(negedge clk) wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd2, v); check("R5 set beats clear", v, 8'h81);
    rd(2'd0, v); check("R2 count after collided edge", v, 8'h41);
    set_pulse(1'b0);
  endtask

  task automatic t_special();
    logic [7:0] v;
    @(negedge clk) special_mode = 1'b1;
    wr(2'd1, 8'hFF);
    check("R9 special write 1", {6'd0, prescale}, 8'h03);
    check("R6 exported enables", {6'd0, tmr_ovf_en, rt_en}, 8'h03);
    rd(2'd1, v); check("R6 bits 3:2 read zero", v, 8'hF3);
    wr(2'd1, 8'h01);
    check("R9 special write 2", {6'd0, prescale}, 8'h01);
    @(negedge clk) special_mode = 1'b0;
    wr(2'd1, 8'h82);
    check("R8 normal write locked", {6'd0, prescale}, 8'h01);
    check("R6 enable write anytime", {6'd0, tmr_ovf_en, rt_en}, 8'h02);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_window_once();
    t_keep_count();
    t_window_edge(63, 2'b01);
    t_window_edge(64, 2'b00);
    t_rising();
    t_falling();
    t_overflow();
    t_collide_write();
    t_collide_clear();
    t_special();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule